// File: doc/BRIEF.md
# Binary64 Square Root with Value-Dependent Early Finish

This block takes one IEEE-754 double-precision operand and returns its square root, rounded to nearest with ties to even. Ordinary operands go through a digit recurrence that produces several root bits per clock. The block finishes early only when the answer can be written down without iterating. That is the case for signed zeros, subnormals (which are flushed to signed zero), infinities, NaNs, negative numbers, and positive values whose stored fraction is zero and whose unbiased exponent is even. The early path always takes the same number of cycles, and so does the full path, so each operation has one of exactly two latencies.

A caller offers an operand with `in_valid` while `in_ready` is high. The block then works on that single operation and takes no new one until it has finished. It signals completion with a one-cycle `out_done` pulse. The pulse carries the 64-bit result and `out_fast`, which tells which of the two paths produced it.

Top module: `sqrt64_early`

## Requirements
- R1: After reset `in_ready` is 1 and `out_done` is 0. An operation starts on a rising edge where `in_valid` and `in_ready` are both 1, and `in_operand` is captured on that edge.
- R2: From the start edge until the edge that raises `out_done`, `in_ready` is 0. Any `in_valid` during that time is ignored: it does not change the result and does not produce an extra `out_done`.
- R3: `out_done` is high for exactly one cycle per operation. `out_fast` is 1 for the early path and 0 for the recurrence path.
- R4: An early-path result appears with `out_done` on the 13th rising edge after the start edge.
- R5: A recurrence-path result appears with `out_done` on the 18th rising edge after the start edge.
- R6: A positive normal operand whose fraction bits [51:0] are all zero and whose unbiased exponent is even (for example 0.25, 1.0, 4.0, 16.0) takes the early path. Its result has a zero fraction and exponent field (E+1023)/2.
- R7: A positive normal operand with a zero fraction and an odd unbiased exponent (for example 2.0 or 0.5) takes the recurrence path.
- R8: A positive normal operand with a nonzero fraction takes the recurrence path, even when its root is exact (9.0 gives 3.0).
- R9: A recurrence-path result is the correctly rounded (round-to-nearest-even) binary64 square root of the operand.
- R10: An operand with exponent field 0 (a zero or a subnormal) takes the early path and returns zero with the operand's sign bit.
- R11: +infinity returns +infinity on the early path. -infinity returns 0xFFF8000000000000 on the early path.
- R12: A NaN operand returns the same bit pattern with bit 51 (the quiet bit) set, on the early path.
- R13: A negative normal operand returns 0xFFF8000000000000 on the early path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Block is idle and will accept an operand |
| in_operand | input | 64 | Binary64 operand |
| out_done | output | 1 | One-cycle completion pulse |
| out_result | output | 64 | Binary64 square root, valid with `out_done` |
| out_fast | output | 1 | Result came from the early path |

## Verification
The bench builds the block with its default parameters: an early latency of 13 cycles, a full latency of 18 cycles, and four root bits per recurrence cycle. With these values the 14 recurrence cycles fit inside the full latency. Both latencies are therefore checked against fixed cycle counts, and recurrence results are compared bit for bit with the simulator's own double-precision root. Pseudo-random exponents and fractions, exponent extremes, and boundary patterns all exercise the rounding.

// File: rtl/sqrt64_pkg.sv
// Shared types and constants for the binary64 square-root block.
package sqrt64_pkg;
    localparam int EXP_W  = 11;
    localparam int FRAC_W = 52;
    localparam int SIG_W  = FRAC_W + 1;
    localparam logic [63:0] NEG_QNAN = 64'hFFF8_0000_0000_0000;
    localparam logic [EXP_W-1:0] EXP_MAX = '1;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  expo;
        logic [FRAC_W-1:0] frac;
    } fp64_t;
endpackage

// File: rtl/sqrt64_classify.sv
// Decodes an operand. It decides whether the answer needs no recurrence and
// forms that answer. It also prepares the significand and exponent for the
// recurrence. Assumes subnormals are flushed to signed zero.
module sqrt64_classify
    import sqrt64_pkg::*;
(
    input  logic [63:0] op_i,
    output logic        fast_o,
    output logic [63:0] fast_res_o,
    output logic [SIG_W:0] sig_o,
    output logic [EXP_W-1:0] exp_o
);
    fp64_t f;
    logic  frac_zero;
    logic [EXP_W:0] half_sum;

    assign f         = op_i;
    assign frac_zero = (f.frac == '0);

    // Choose the path and the early answer from the operand class.
    always_comb begin
        half_sum   = ({1'b0, f.expo} + 12'd1023) >> 1;
        fast_o     = 1'b1;
        fast_res_o = '0;
        if (f.expo == '0) begin
            fast_res_o = {f.sign, 63'd0};
        end else if (f.expo == EXP_MAX) begin
            if (frac_zero) fast_res_o = f.sign ? NEG_QNAN : {1'b0, EXP_MAX, 52'd0};
            else           fast_res_o = op_i | (64'd1 << 51);
        end else if (f.sign) begin
            fast_res_o = NEG_QNAN;
        end else if (frac_zero && f.expo[0]) begin
            fast_res_o = {1'b0, half_sum[EXP_W-1:0], 52'd0};
        end else begin
            fast_o = 1'b0;
        end
    end

    // Make the unbiased exponent even by doubling the significand when it is odd.
    always_comb begin
        logic [EXP_W:0] adj;
        if (f.expo[0]) begin
            sig_o = {1'b0, 1'b1, f.frac};
            adj   = {1'b0, f.expo};
        end else begin
            sig_o = {1'b1, f.frac, 1'b0};
            adj   = {1'b0, f.expo} - 12'd1;
        end
        exp_o = EXP_W'((adj + 12'd1023) >> 1);
    end
endmodule

// File: rtl/sqrt64_recur.sv
// One clock's worth of restoring square-root recurrence: BPC root bits.
// Each step brings in two radicand bits. Assumes the remainder fits in RW bits.
module sqrt64_recur #(
    parameter int ROOT_W = 56,
    parameter int BPC    = 4,
    localparam int RW    = ROOT_W + 3
) (
    input  logic [RW-1:0]     rem_i,
    input  logic [ROOT_W-1:0] root_i,
    input  logic [2*BPC-1:0]  pairs_i,
    output logic [RW-1:0]     rem_o,
    output logic [ROOT_W-1:0] root_o
);
    logic [RW-1:0]     rem_s  [BPC+1];
    logic [ROOT_W-1:0] root_s [BPC+1];

    assign rem_s[0]  = rem_i;
    assign root_s[0] = root_i;

    for (genvar g = 0; g < BPC; g++) begin : g_step
        logic [RW-1:0] shifted;
        logic [RW-1:0] trial;
        logic          take;
        // Try subtracting 4*root+1 from the extended remainder.
        assign shifted     = {rem_s[g][RW-3:0], pairs_i[2*(BPC-g)-1 -: 2]};
        assign trial       = {{(RW-ROOT_W-2){1'b0}}, root_s[g], 2'b01};
        assign take        = (shifted >= trial);
        assign rem_s[g+1]  = take ? shifted - trial : shifted;
        assign root_s[g+1] = {root_s[g][ROOT_W-2:0], take};
    end

    assign rem_o  = rem_s[BPC];
    assign root_o = root_s[BPC];
endmodule

// File: rtl/sqrt64_round.sv
// Rounds the finished root to nearest-even and packs the binary64 result.
// Assumes the root's top bit is set and that ROOT_W is at least 54.
module sqrt64_round
    import sqrt64_pkg::*;
#(
    parameter int ROOT_W = 56,
    localparam int EXTRA = ROOT_W - SIG_W
) (
    input  logic [ROOT_W-1:0] root_i,
    input  logic              rem_nz_i,
    input  logic [EXP_W-1:0]  exp_i,
    output logic [63:0]       res_o
);
    logic        guard;
    logic        sticky;
    logic        up;
    logic [SIG_W:0] sum;

    assign guard = root_i[EXTRA-1];
    if (EXTRA > 1) begin : g_low
        assign sticky = (|root_i[EXTRA-2:0]) | rem_nz_i;
    end else begin : g_nolow
        assign sticky = rem_nz_i;
    end

    // Add one unit in the last place when guard is set and the tie breaks upward.
    assign up  = guard & (sticky | root_i[EXTRA]);
    assign sum = {1'b0, root_i[ROOT_W-1 -: SIG_W]} + {{SIG_W{1'b0}}, up};

    // Pack the result and absorb a carry out of the significand.
    always_comb begin
        if (sum[SIG_W]) res_o = {1'b0, exp_i + 11'd1, sum[SIG_W-1:1]};
        else            res_o = {1'b0, exp_i, sum[FRAC_W-1:0]};
    end
endmodule

// File: rtl/sqrt64_early.sv
// Binary64 square root with two fixed latencies. Handles one operation at a time.
// Trivial operands finish after FAST_LAT edges and all others after SLOW_LAT.
// Assumes ceil(54/BPC) < SLOW_LAT and 1 < FAST_LAT.
module sqrt64_early
    import sqrt64_pkg::*;
#(
    parameter int FAST_LAT = 13,
    parameter int SLOW_LAT = 18,
    parameter int BPC      = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [63:0] in_operand,
    output logic        out_done,
    output logic [63:0] out_result,
    output logic        out_fast
);
    localparam int ITERS  = (SIG_W + 1 + BPC - 1) / BPC;
    localparam int ROOT_W = ITERS * BPC;
    localparam int RW     = ROOT_W + 3;
    localparam int XW     = 2 * ROOT_W;
    localparam int CW     = $clog2(SLOW_LAT + 2);
    localparam logic [CW-1:0] FAST_M1 = CW'(FAST_LAT - 1);
    localparam logic [CW-1:0] SLOW_M1 = CW'(SLOW_LAT - 1);
    localparam logic [CW-1:0] ITER_N  = CW'(ITERS);

    logic                busy;
    logic [CW-1:0]       cyc;
    logic                fast_q;
    logic [63:0]         fast_res_q;
    logic [EXP_W-1:0]    exp_q;
    logic [XW-1:0]       x_q;
    logic [RW-1:0]       rem_q, rem_n;
    logic [ROOT_W-1:0]   root_q, root_n;
    logic                start;
    logic                cls_fast;
    logic [63:0]         cls_res;
    logic [SIG_W:0]      cls_sig;
    logic [EXP_W-1:0]    cls_exp;
    logic [63:0]         slow_res;

    assign in_ready = ~busy;
    assign start    = in_valid & ~busy;

    sqrt64_classify u_cls (
        .op_i(in_operand), .fast_o(cls_fast), .fast_res_o(cls_res),
        .sig_o(cls_sig), .exp_o(cls_exp)
    );

    sqrt64_recur #(.ROOT_W(ROOT_W), .BPC(BPC)) u_rec (
        .rem_i(rem_q), .root_i(root_q), .pairs_i(x_q[XW-1 -: 2*BPC]),
        .rem_o(rem_n), .root_o(root_n)
    );

    sqrt64_round #(.ROOT_W(ROOT_W)) u_rnd (
        .root_i(root_q), .rem_nz_i(rem_q != '0), .exp_i(exp_q), .res_o(slow_res)
    );

    // Sequence one operation: capture, count to its latency, emit the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            cyc        <= '0;
            fast_q     <= 1'b0;
            fast_res_q <= '0;
            exp_q      <= '0;
            out_done   <= 1'b0;
            out_fast   <= 1'b0;
            out_result <= '0;
        end else begin
            out_done <= 1'b0;
            if (start) begin
                busy       <= 1'b1;
                cyc        <= '0;
                fast_q     <= cls_fast;
                fast_res_q <= cls_res;
                exp_q      <= cls_exp;
            end else if (busy) begin
                cyc <= cyc + 1'b1;
                if (cyc == (fast_q ? FAST_M1 : SLOW_M1)) begin
                    busy       <= 1'b0;
                    out_done   <= 1'b1;
                    out_fast   <= fast_q;
                    out_result <= fast_q ? fast_res_q : slow_res;
                end
            end
        end
    end

    // Load the radicand and advance the recurrence for ITERS cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q    <= '0;
            rem_q  <= '0;
            root_q <= '0;
        end else if (start) begin
            x_q    <= {cls_sig, {(XW-SIG_W-1){1'b0}}};
            rem_q  <= '0;
            root_q <= '0;
        end else if (busy && !fast_q && cyc < ITER_N) begin
            x_q    <= x_q << (2*BPC);
            rem_q  <= rem_n;
            root_q <= root_n;
        end
    end

    // Independent count of edges since the last start, for the latency checks.
    logic [CW-1:0] chk_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)                             chk_cnt <= '0;
        else if (in_valid && in_ready)          chk_cnt <= CW'(1);
        else if (out_done)                      chk_cnt <= '0;
        else if (chk_cnt != '0 && chk_cnt <= SLOW_M1 + 1'b1) chk_cnt <= chk_cnt + 1'b1;
    end

    AST_START_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);                               // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |=> !out_done);                                             // R3
    AST_FAST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_done && out_fast) |-> chk_cnt == CW'(FAST_LAT + 1));            // R4
    AST_SLOW_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_done && !out_fast) |-> chk_cnt == CW'(SLOW_LAT + 1));           // R5
    AST_FAST_ROOT_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        (out_done && out_fast && !out_result[63] && out_result[62:52] != EXP_MAX)
        |-> out_result[51:0] == '0);                                         // R6
    AST_SLOW_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_done && !out_fast) |-> (!out_result[63] && out_result[62:52] != '0
        && out_result[62:52] != EXP_MAX));                                   // R9
endmodule

// File: tb/tb_sqrt64_early.sv
module tb_sqrt64_early;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        in_ready;
    logic [63:0] in_operand;
    logic        out_done;
    logic [63:0] out_result;
    logic        out_fast;

    int nchk = 0;
    int nerr = 0;
    logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

    always #2 clk = ~clk;

    sqrt64_early dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_operand(in_operand), .out_done(out_done), .out_result(out_result),
        .out_fast(out_fast)
    );

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_root(input logic [63:0] x);
        return $realtobits($sqrt($bitstoreal(x)));
    endfunction

    // Expected path for a positive normal operand (R6, R7, R8).
    function automatic logic pos_fast(input logic [63:0] x);
        return (x[51:0] == '0) && x[52];
    endfunction

    // Issue one operand, measure the latency and compare the result.
    task automatic run_op(input logic [63:0] op, input logic [63:0] exp_res,
                          input logic exp_fast, input string tag);
        int n;
        logic got;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid   = 1'b1;
        in_operand = op;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        n = 0;
        got = 1'b0;
        while (!got && n < 40) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            got = out_done;
        end
        chk(got && out_result == exp_res, {tag, " result"}, out_result, exp_res);
        chk(out_fast == exp_fast, {tag, " path flag R3"}, 64'(out_fast), 64'(exp_fast));
        if (exp_fast) chk(n == 13, {tag, " early latency R4"}, 64'(n), 64'd13);
        else          chk(n == 18, {tag, " full latency R5"}, 64'(n), 64'd18);
        @(posedge clk);
        @(negedge clk);
        chk(!out_done, {tag, " single pulse R3"}, 64'(out_done), 64'd0);
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk(in_ready == 1'b1, "R1 ready after reset", 64'(in_ready), 64'd1);
        chk(out_done == 1'b0, "R1 no done after reset", 64'(out_done), 64'd0);
    endtask

    task automatic test_even_pow2();
        run_op(64'h3FD0_0000_0000_0000, 64'h3FE0_0000_0000_0000, 1'b1, "R6 0.25");
        run_op(64'h3FF0_0000_0000_0000, 64'h3FF0_0000_0000_0000, 1'b1, "R6 1.0");
        run_op(64'h4010_0000_0000_0000, 64'h4000_0000_0000_0000, 1'b1, "R6 4.0");
        run_op(64'h4030_0000_0000_0000, 64'h4010_0000_0000_0000, 1'b1, "R6 16.0");
        run_op(64'h0010_0000_0000_0000, 64'h2000_0000_0000_0000, 1'b1, "R6 min normal");
    endtask

    task automatic test_odd_pow2();
        run_op(64'h4000_0000_0000_0000, ref_root(64'h4000_0000_0000_0000), 1'b0, "R7 2.0");
        run_op(64'h3FE0_0000_0000_0000, ref_root(64'h3FE0_0000_0000_0000), 1'b0, "R7 0.5");
        run_op(64'h7FE0_0000_0000_0000, ref_root(64'h7FE0_0000_0000_0000), 1'b0, "R7 2^1023");
    endtask

    task automatic test_exact_square();
        run_op(64'h4022_0000_0000_0000, 64'h4008_0000_0000_0000, 1'b0, "R8 9.0");
        run_op(64'h4008_0000_0000_0000, ref_root(64'h4008_0000_0000_0000), 1'b0, "R8 3.0");
    endtask

    task automatic test_rounding();
        logic [63:0] op;
        run_op($realtobits(0.15), ref_root($realtobits(0.15)), 1'b0, "R9 0.15");
        run_op(64'h7FEF_FFFF_FFFF_FFFF, ref_root(64'h7FEF_FFFF_FFFF_FFFF), 1'b0, "R9 max");
        run_op(64'h3FFF_FFFF_FFFF_FFFF, ref_root(64'h3FFF_FFFF_FFFF_FFFF), 1'b0, "R9 below 2");
        run_op(64'h0010_0000_0000_0001, ref_root(64'h0010_0000_0000_0001), 1'b0, "R9 small");
        for (int i = 0; i < 48; i++) begin
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 7);
            lfsr = lfsr ^ (lfsr << 17);
            op = {1'b0, lfsr[62:52], lfsr[51:0]};
            if (op[62:52] == 11'd0)    op[62:52] = 11'd1;
            if (op[62:52] == 11'h7FF)  op[62:52] = 11'h7FE;
            run_op(op, ref_root(op), pos_fast(op), "R9 pattern");
        end
    endtask

    task automatic test_specials();
        run_op(64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000, 1'b1, "R10 +0");
        run_op(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b1, "R10 -0");
        run_op(64'h0000_0000_0000_0123, 64'h0000_0000_0000_0000, 1'b1, "R10 +subnormal");
        run_op(64'h8008_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b1, "R10 -subnormal");
        run_op(64'h7FF0_0000_0000_0000, 64'h7FF0_0000_0000_0000, 1'b1, "R11 +inf");
        run_op(64'hFFF0_0000_0000_0000, 64'hFFF8_0000_0000_0000, 1'b1, "R11 -inf");
        run_op(64'h7FF8_0000_0000_0001, 64'h7FF8_0000_0000_0001, 1'b1, "R12 quiet NaN");
        run_op(64'h7FF0_0000_0000_0001, 64'h7FF8_0000_0000_0001, 1'b1, "R12 signalling NaN");
        run_op(64'hFFF0_0000_0000_0005, 64'hFFF8_0000_0000_0005, 1'b1, "R12 negative NaN");
        run_op(64'hC010_0000_0000_0000, 64'hFFF8_0000_0000_0000, 1'b1, "R13 -4.0");
        run_op(64'hBFC3_3333_3333_3333, 64'hFFF8_0000_0000_0000, 1'b1, "R13 -0.15");
    endtask

    // Offer a second operand while busy; it must be dropped.
    task automatic test_busy_ignore();
        int n;
        int dones;
        logic [63:0] a;
        a = $realtobits(0.15);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_operand = a;
        @(posedge clk);
        n = 0;
        dones = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            in_operand = 64'h4010_0000_0000_0000;
            in_valid = 1'b1;
            chk(in_ready == 1'b0, "R2 ready low while busy", 64'(in_ready), 64'd0);
            @(posedge clk);
            n++;
        end
        @(negedge clk);
        in_valid = 1'b0;
        while (!out_done && n < 40) begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end
        chk(out_done && out_result == ref_root(a), "R2 result kept", out_result, ref_root(a));
        chk(n == 18, "R2 latency unaffected", 64'(n), 64'd18);
        for (int k = 0; k < 25; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (out_done) dones++;
        end
        chk(dones == 0, "R2 no extra done", 64'(dones), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        in_valid = 1'b0;
        in_operand = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_even_pow2();
        test_odd_pow2();
        test_exact_square();
        test_rounding();
        test_specials();
        test_busy_ignore();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule